// File: doc/BRIEF.md
# I2C slave register interface

This block is a two-wire serial slave that lets a host microcontroller read and write a small bank of 8-bit configuration registers and one read-only status register. The bus lines are brought into a faster system clock through a synchroniser. START and STOP conditions are detected there, and the protocol is then run bit by bit. The block answers a single fixed 7-bit device address. SDA is driven only through an open-drain enable, and the block acknowledges each byte it receives.

A write transaction carries a register pointer byte and then any number of data bytes. A read transaction returns bytes starting at the register the pointer currently selects. The pointer survives between transactions and always points one past the last register touched. A host can therefore read the next register by sending only the read command byte, or can set the pointer in a write and read after a repeated START. When a read transaction ends with STOP, the block pulses a standby request towards the power control logic.

Top module: `cfgbus_i2c_target`

## Requirements
- R1: The slave acknowledges only the address bytes 0x7C (write) and 0x7D (read), whose upper seven bits are 0111110 and whose bit 0 is the direction, 1 meaning read. After any other address byte it keeps SDA released until the next START, and it acknowledges nothing in the bytes that follow.
- R2: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. A STOP returns the slave to idle with SDA released.
- R3: Bytes are transferred MSB first. The slave pulls SDA low during the ninth SCL clock of every byte it accepts. The SDA enable changes only while SCL is low, except when it is released at a START or STOP.
- R4: In a write transaction, the first byte after the address loads the register pointer. Each later byte is written to the register the pointer selects, and the pointer then advances by one.
- R5: A read shifts out the register the pointer selects, and the pointer then advances by one. A master acknowledge continues the burst with the next register. A master no-acknowledge ends the burst.
- R6: The pointer keeps its value between transactions, so a read that has only the read command byte returns the register after the last one accessed. The pointer wraps from 0xFF to 0x00.
- R7: Address 0x0F is read-only. Its bit 4 shows pwr_good_i, its bit 2 shows silence_i, and its other bits read 0. Writes to 0x0F and to addresses 0x11 to 0xFF are acknowledged but change nothing. Reads of 0x11 to 0xFF return 0x00.
- R8: After reset, register 0x0E holds 0x02, register 0x10 holds 0xA8, and every other writable register holds 0x00. The pointer is 0x00, SDA is released and the standby request is low.
- R9: A STOP that ends a transaction whose last address byte was a matching read pulses standby_req_o high for exactly one clock. A STOP after a write, or after a rejected address, gives no pulse.
- R10: A repeated START restarts address decoding with a cleared bit count and leaves the register pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain); 0 releases it |
| pwr_good_i | input | 1 | Power-good flag shown in bit 4 of register 0x0F |
| silence_i | input | 1 | Silence-detected flag shown in bit 2 of register 0x0F |
| standby_req_o | output | 1 | One-clock pulse when a read transaction ends with STOP |
| regs_o | output | 8*NUM_REGS | Register contents, register k in bits 8k+7..8k; the 0x0F slot is 0 |

## Verification
If the register pointer is wrong, the first data byte of the next read returns a wrong value, and a bare current-address read brings it out within one byte time. A protocol state that has drifted out of step shows up within the same byte: an acknowledge is missing or misplaced on the ninth clock, or the read data bits come out shifted. A bad decode of the write strobe shows up on regs_o on the clock after the byte's eighth bit, and a missing or extra standby pulse shows up at the STOP itself.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

    localparam int PTR_W  = 8;
    localparam int BYTE_W = 8;

    localparam logic [6:0] DEV_ADDR = 7'b0111110;

    localparam logic [PTR_W-1:0] STATUS_IDX = 8'h0F;
    localparam int PG_BIT  = 4;
    localparam int SIL_BIT = 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } phase_t;

    // Synchronised bus levels and the events derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // One-cycle register write request
    typedef struct packed {
        logic  en;
        ptr_t  addr;
        byte_t data;
    } wr_req_t;

    function automatic byte_t reset_value(input int idx);
        case (idx)
            14:      return 8'h02;
            16:      return 8'hA8;
            default: return 8'h00;
        endcase
    endfunction

    function automatic byte_t status_byte(input logic pg, input logic sil);
        byte_t b;
        b          = '0;
        b[PG_BIT]  = pg;
        b[SIL_BIT] = sil;
        return b;
    endfunction

endpackage

// File: rtl/cfgbus_line_sync.sv
module cfgbus_line_sync
    import cfgbus_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_now = scl_pipe[STAGES-1];
    assign sda_now = sda_pipe[STAGES-1];

    always_comb begin
        ev.scl      = scl_now;
        ev.sda      = sda_now;
        ev.scl_rise = scl_now & ~scl_prev;
        ev.scl_fall = ~scl_now & scl_prev;
        // SDA edges only count while SCL stays high across both samples
        ev.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        ev.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
    end

endmodule

// File: rtl/cfgbus_engine.sv
module cfgbus_engine
    import cfgbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  byte_t   rd_data,
    output ptr_t    ptr,
    output wr_req_t wr,
    output logic    sda_oe,
    output logic    standby_req
);

    phase_t     st;
    logic [2:0] bitcnt;
    logic       got8;
    byte_t      rx;
    byte_t      tx;
    logic       ptr_pending;
    logic       was_read;
    logic       m_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            bitcnt      <= '0;
            got8        <= 1'b0;
            rx          <= '0;
            tx          <= '0;
            ptr         <= '0;
            wr          <= '0;
            sda_oe      <= 1'b0;
            standby_req <= 1'b0;
            ptr_pending <= 1'b0;
            was_read    <= 1'b0;
            m_ack       <= 1'b0;
        end else begin
            wr.en       <= 1'b0;
            standby_req <= 1'b0;
            if (ev.start) begin
                st          <= ST_ADDR;
                bitcnt      <= '0;
                got8        <= 1'b0;
                sda_oe      <= 1'b0;
                was_read    <= 1'b0;
                ptr_pending <= 1'b1;
            end else if (ev.stop) begin
                st          <= ST_IDLE;
                sda_oe      <= 1'b0;
                standby_req <= was_read;
                was_read    <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (ev.scl_rise) begin
                            rx     <= {rx[6:0], ev.sda};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) got8 <= 1'b1;
                        end else if (ev.scl_fall && got8) begin
                            got8 <= 1'b0;
                            if (st == ST_ADDR) begin
                                if (rx[7:1] == DEV_ADDR) begin
                                    sda_oe   <= 1'b1;
                                    was_read <= rx[0];
                                    st       <= ST_ADDR_ACK;
                                end else begin
                                    st <= ST_IGNORE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                st     <= ST_WR_ACK;
                                if (ptr_pending) begin
                                    ptr         <= rx;
                                    ptr_pending <= 1'b0;
                                end else begin
                                    wr.en   <= 1'b1;
                                    wr.addr <= ptr;
                                    wr.data <= rx;
                                    ptr     <= ptr + ptr_t'(1);
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            bitcnt <= '0;
                            if (was_read) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr + ptr_t'(1);
                                st     <= ST_RD_BYTE;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            st     <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (ev.scl_rise) begin
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) got8 <= 1'b1;
                        end else if (ev.scl_fall) begin
                            if (got8) begin
                                got8   <= 1'b0;
                                sda_oe <= 1'b0;
                                st     <= ST_RD_ACK;
                            end else begin
                                tx     <= {tx[6:0], tx[7]};
                                sda_oe <= ~tx[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) begin
                            m_ack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (m_ack) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr + ptr_t'(1);
                                bitcnt <= '0;
                                st     <= ST_RD_BYTE;
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: a rejected address leaves SDA released while ignoring the bus
    p_ignore_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IGNORE) |-> !sda_oe);

    // R3: the SDA enable moves only while SCL is low, or at START/STOP
    p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> (!$past(ev.scl) || $past(ev.start) || $past(ev.stop)));

    // R6: after a data write the pointer sits one past the written register
    p_ptr_after_write_r6: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (ptr == ptr_t'(wr.addr + ptr_t'(1))));

    // R9: the standby request is a single-clock pulse
    p_standby_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        standby_req |=> !standby_req);

    // R10: START rearms address decoding and keeps the pointer
    p_rstart_keeps_ptr_r10: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (st == ST_ADDR && bitcnt == 3'd0 && ptr == $past(ptr)));

endmodule

// File: rtl/cfgbus_regbank.sv
module cfgbus_regbank
    import cfgbus_pkg::*;
#(
    parameter int NUM_REGS = 17
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wr_req_t               wr,
    input  ptr_t                  rd_addr,
    input  logic                  pwr_good,
    input  logic                  silence,
    output byte_t                 rd_data,
    output logic [8*NUM_REGS-1:0] regs_o
);

    localparam int FLAT_W = 8 * NUM_REGS;

    logic [FLAT_W-1:0] view_flat;

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            if (i == int'(STATUS_IDX)) begin : g_ro
                assign view_flat[8*i +: 8] = status_byte(pwr_good, silence);
                assign regs_o[8*i +: 8]    = '0;
            end else begin : g_rw
                byte_t q;
                always_ff @(posedge clk) begin
                    if (rst)
                        q <= reset_value(i);
                    else if (wr.en && wr.addr == ptr_t'(i))
                        q <= wr.data;
                end
                assign view_flat[8*i +: 8] = q;
                assign regs_o[8*i +: 8]    = q;
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_addr == ptr_t'(k)) rd_data = view_flat[8*k +: 8];
        end
    end

    // R7: writes to the status slot or past the bank change no register
    p_discard_ro_r7: assert property (@(posedge clk) disable iff (rst)
        (wr.en && (int'(wr.addr) >= NUM_REGS || wr.addr == STATUS_IDX)) |=> $stable(regs_o));

endmodule

// File: rtl/cfgbus_i2c_target.sv
module cfgbus_i2c_target
    import cfgbus_pkg::*;
#(
    parameter int NUM_REGS    = 17,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic                  pwr_good_i,
    input  logic                  silence_i,
    output logic                  standby_req_o,
    output logic [8*NUM_REGS-1:0] regs_o
);

    bus_ev_t ev;
    byte_t   rd_data;
    ptr_t    ptr;
    wr_req_t wr;

    cfgbus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_i),
        .sda_in (sda_i),
        .ev     (ev)
    );

    cfgbus_engine u_engine (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .rd_data     (rd_data),
        .ptr         (ptr),
        .wr          (wr),
        .sda_oe      (sda_oe_o),
        .standby_req (standby_req_o)
    );

    cfgbus_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .rd_addr  (ptr),
        .pwr_good (pwr_good_i),
        .silence  (silence_i),
        .rd_data  (rd_data),
        .regs_o   (regs_o)
    );

endmodule

// File: tb/test_cfgbus_i2c_target.sv
`timescale 1ns/1ps
module test_cfgbus_i2c_target;

    localparam int NREG = 17;
    localparam int Q    = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic pg = 1'b0;
    logic sil = 1'b0;
    logic sda_oe;
    logic sby;
    logic [8*NREG-1:0] regs;
    logic sda_line;

    int n_total = 0;
    int n_bad = 0;
    int sby_cnt = 0;
    int exp_sby = 0;
    bit done = 0;

    logic [7:0] exp_reg [NREG];
    logic [7:0] exp_ptr;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    cfgbus_i2c_target #(.NUM_REGS(NREG)) i_cfgbus_i2c_target (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (m_scl),
        .sda_i         (sda_line),
        .sda_oe_o      (sda_oe),
        .pwr_good_i    (pg),
        .silence_i     (sil),
        .standby_req_o (sby),
        .regs_o        (regs)
    );

    always @(posedge clk) if (!rst && sby) sby_cnt <= sby_cnt + 1;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (int'(a) >= NREG) return 8'h00;
        if (a == 8'h0F) return {3'b000, pg, 1'b0, sil, 2'b00};
        return exp_reg[a];
    endfunction

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hq();
        m_scl = 1'b1; hq();
        m_sda = 1'b0; hq();
        m_scl = 1'b0; hq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hq();
        m_scl = 1'b1; hq();
        m_sda = 1'b1; hq();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hq();
            m_scl = 1'b1; hq();
            m_scl = 1'b0; hq();
        end
        m_sda = 1'b1; hq();
        m_scl = 1'b1; hq();
        acked = ~sda_line;
        m_scl = 1'b0; hq();
    endtask

    task automatic get_byte(output logic [7:0] b, input logic give_ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; hq();
            m_scl = 1'b1; hq();
            b[i] = sda_line;
            m_scl = 1'b0; hq();
        end
        m_sda = ~give_ack; hq();
        m_scl = 1'b1; hq();
        m_scl = 1'b0; hq();
        m_sda = 1'b1;
    endtask

    task automatic open_write(input logic [7:0] p);
        logic a;
        bus_start();
        put_byte(8'h7C, a);
        chk("R1 write address ack", {7'b0, a}, 8'h01);
        put_byte(p, a);
        chk("R3 pointer byte ack", {7'b0, a}, 8'h01);
        exp_ptr = p;
    endtask

    task automatic put_data(input logic [7:0] d);
        logic a;
        put_byte(d, a);
        chk("R3 data byte ack", {7'b0, a}, 8'h01);
        if (int'(exp_ptr) < NREG && exp_ptr != 8'h0F) exp_reg[exp_ptr] = d;
        exp_ptr = exp_ptr + 8'd1;
    endtask

    task automatic open_read();
        logic a;
        bus_start();
        put_byte(8'h7D, a);
        chk("R1 read address ack", {7'b0, a}, 8'h01);
    endtask

    task automatic get_data(input logic more, input string tag);
        logic [7:0] b;
        get_byte(b, more);
        chk(tag, b, model_read(exp_ptr));
        exp_ptr = exp_ptr + 8'd1;
    endtask

    task automatic end_read();
        bus_stop(); hq();
        exp_sby++;
        chk("R9 standby pulse after read", 8'(sby_cnt), 8'(exp_sby));
        chk("R2 SDA released after STOP", {7'b0, sda_oe}, 8'h00);
    endtask

    task automatic end_write();
        bus_stop(); hq();
        chk("R9 no standby after write", 8'(sby_cnt), 8'(exp_sby));
        chk("R2 SDA released after STOP", {7'b0, sda_oe}, 8'h00);
    endtask

    task automatic check_regs(input string tag);
        for (int k = 0; k < NREG; k++)
            chk(tag, regs[8*k +: 8], (k == 15) ? 8'h00 : exp_reg[k]);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NREG; k++)
            exp_reg[k] = (k == 14) ? 8'h02 : (k == 16) ? 8'hA8 : 8'h00;
        exp_ptr = 8'h00;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        hq();

        // R8 reset state
        chk("R8 SDA released at reset", {7'b0, sda_oe}, 8'h00);
        chk("R8 standby low at reset", {7'b0, sby}, 8'h00);
        check_regs("R8 reset defaults");
        open_read();
        get_data(1'b0, "R8 pointer zero after reset");
        end_read();

        // R4 write burst from a loaded pointer
        open_write(8'h03);
        put_data(8'h11); put_data(8'h22); put_data(8'h33); put_data(8'h44);
        end_write();
        check_regs("R4 write burst");

        // R10 repeated START keeps pointer, R5 read burst
        open_write(8'h04);
        open_read();
        get_data(1'b1, "R10 read after repeated START");
        get_data(1'b0, "R5 second burst byte");
        end_read();

        // R6 bare current-address read
        open_read();
        get_data(1'b0, "R6 current-address read");
        end_read();

        // R4 whole bank written arithmetically, status slot discarded
        open_write(8'h00);
        for (int k = 0; k < NREG; k++) put_data(8'((k * 37 + 5) & 255));
        end_write();
        check_regs("R4 full bank write");

        // R7 status register swept over its inputs
        for (int c = 0; c < 4; c++) begin
            pg  = c[1];
            sil = c[0];
            open_write(8'h0F);
            open_read();
            get_data(1'b0, "R7 status register");
            end_read();
        end

        // R5 burst read over the whole bank and past its end
        open_write(8'h00);
        open_read();
        for (int k = 0; k < NREG + 2; k++) get_data(k < NREG + 1, "R5 full bank read");
        end_read();

        // R7 unimplemented address write discarded, reads zero
        open_write(8'h20);
        put_data(8'h5A);
        end_write();
        check_regs("R7 unimplemented write discarded");
        open_write(8'h20);
        open_read();
        get_data(1'b0, "R7 unimplemented read zero");
        end_read();

        // R6 pointer wrap on write and on read
        open_write(8'hFF);
        put_data(8'h77);
        put_data(8'h99);
        end_write();
        check_regs("R6 write wraps to 0x00");
        open_read();
        get_data(1'b0, "R6 pointer after wrap");
        end_read();
        open_write(8'hFE);
        open_read();
        get_data(1'b1, "R6 read wrap");
        get_data(1'b1, "R6 read wrap");
        get_data(1'b0, "R6 read wrap");
        end_read();

        // R1 address decode sweep, both directions
        for (int rw = 0; rw < 2; rw++) begin
            for (int a = 0; a < 128; a++) begin
                logic ack;
                if (rw == 1 && a == 'h3E) continue;
                bus_start();
                put_byte({7'(a), 1'(rw)}, ack);
                chk("R1 address decode", {7'b0, ack}, (a == 'h3E) ? 8'h01 : 8'h00);
                if (a != 'h3E && (a % 16) == 0) begin
                    put_byte(8'h00, ack);
                    chk("R1 bytes ignored after mismatch", {7'b0, ack}, 8'h00);
                end
                end_write();
            end
        end
        check_regs("R1 rejected traffic leaves registers");
        open_read();
        get_data(1'b0, "R6 pointer kept across rejected traffic");
        end_read();

        done = 1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule